// File: doc/BRIEF.md
# CAN Error-Status Flag Register

This block is the receiver-side flag register of a CAN controller. It watches the transmit and receive error counters, turns them into a two-bit receiver status and a two-bit transmitter status, and raises a status-change flag whenever either status moves. While that flag is pending, the reported status stays frozen, so software always reads the status that caused the interrupt. The register also holds three sticky event flags: wake-up, receive overrun and receive-buffer-full. Each is set by a strobe from the protocol engine.

Software reads the register through a small read/write port and clears flags by writing ones. Each flag drives one interrupt line, gated by a per-line enable input. During initialization mode the flags are forced to zero and writes are ignored, but the status fields keep following the counters.

Top module: `can_errstat_reg`

## Requirements
- R1: When reset is released the register reads 0x00 and all four interrupt lines are low.
- R2: A read at address 0x04 returns, from bit 7 down to bit 0: wake-up flag, status-change flag, receiver status (2 bits), transmitter status (2 bits), overrun flag, receive-full flag. Every other address reads 0x00.
- R3: A write at 0x04, made with the register writable, clears each flag whose data bit is 1 at that clock edge. Flags whose data bit is 0 are unchanged, and a write at any other address changes nothing.
- R4: Writes never change bits 5:2 (the two status fields).
- R5: Receiver status is 00 for a receive count of 0..96, 01 for 97..127 and 10 above 127.
- R6: Transmitter status is 00 for a transmit count of 0..96, 01 for 97..127 and 10 above 127. When the transmit count exceeds 255, both status fields are 11.
- R7: When no status-change flag is pending and the status derived from the counters differs from the reported status, the reported fields take the new value and the status-change flag sets at the same clock edge.
- R8: While the status-change flag is set, both status fields hold their value whatever the counters do.
- R9: Once the status-change flag is cleared, a status that still differs is reported and the flag sets again at the next edge.
- R10: While the initialization request and acknowledge are both high, all four flags are held at 0. Writes take effect only when request and acknowledge are both low. The status fields keep tracking the counters in initialization mode without setting the status-change flag.
- R11: The wake-up flag sets when bus activity is seen while the sleep input is high; bus activity alone does not set it. The overrun and receive-full flags set on their strobes.
- R12: A set event and a clearing write to the same flag in the same cycle leave the flag set.
- R13: The interrupt lines are irq[3]=wake-up, irq[2]=status change, irq[1]=overrun and irq[0]=receive full, each being its flag ANDed with the matching irq_en bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | ADDR_W | Register address |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data (1 clears the flag) |
| rdata | output | 8 | Combinational read data |
| init_req | input | 1 | Initialization mode request |
| init_ack | input | 1 | Initialization mode acknowledge |
| sleep_mode | input | 1 | Controller is asleep |
| bus_activity | input | 1 | Bus activity detected |
| overrun_evt | input | 1 | Receive overrun strobe |
| rxfull_evt | input | 1 | Receive buffer full strobe |
| tx_err_cnt | input | CNT_W | Transmit error counter |
| rx_err_cnt | input | CNT_W | Receive error counter |
| irq_en | input | 4 | Interrupt enables, same order as irq |
| irq | output | 4 | Interrupt lines |

## Verification
Every flag and status field is a single register stage. A counter, strobe or write presented in one cycle is therefore visible on rdata and irq right after the next rising edge. The one exception is a status that still differs when its pending flag is cleared: it appears one edge later. A changed address or enable shows up at once, because the read path and the interrupt gating are combinational. The bench drives inputs at the falling edge and compares against its model at the following falling edge, so each check lands one full edge after its stimulus. The delayed re-report is checked across two consecutive falling edges.

// File: rtl/can_errstat_pkg.sv
package can_errstat_pkg;

    // Two-bit error standing, shared by the receiver and transmitter fields
    typedef enum logic [1:0] {
        ST_OK      = 2'b00,
        ST_WARN    = 2'b01,
        ST_PASSIVE = 2'b10,
        ST_BUSOFF  = 2'b11
    } errst_e;

    // Register image; field order is the visible bit order (MSB first)
    typedef struct packed {
        logic   wake;
        logic   csc;
        errst_e rstat;
        errst_e tstat;
        logic   ovr;
        logic   rxf;
    } flagreg_t;

    // State of the status tracker
    typedef struct packed {
        errst_e rstat;
        errst_e tstat;
        logic   csc;
    } trk_state_t;

    localparam int NUM_EVT_FLAGS = 3;
    localparam int EVT_RXF  = 0;
    localparam int EVT_OVR  = 1;
    localparam int EVT_WAKE = 2;
    localparam int NUM_CNT  = 2;
    localparam int CNT_RX   = 0;
    localparam int CNT_TX   = 1;

endpackage

// File: rtl/can_errstat_level.sv
module can_errstat_level
    import can_errstat_pkg::*;
#(
    parameter int CNT_W       = 9,
    parameter int WARN_LIM    = 96,
    parameter int PASSIVE_LIM = 127
) (
    input  logic [CNT_W-1:0] cnt,
    input  logic             force_off,
    output errst_e           level
);

    localparam logic [CNT_W-1:0] WARN_CMP    = CNT_W'(WARN_LIM);
    localparam logic [CNT_W-1:0] PASSIVE_CMP = CNT_W'(PASSIVE_LIM);

    always_comb begin
        if (force_off) begin
            level = ST_BUSOFF;
        end else if (cnt > PASSIVE_CMP) begin
            level = ST_PASSIVE;
        end else if (cnt > WARN_CMP) begin
            level = ST_WARN;
        end else begin
            level = ST_OK;
        end
    end

endmodule

// File: rtl/can_errstat_flag.sv
module can_errstat_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic hold_zero,
    input  logic set_evt,
    input  logic clr_req,
    output logic flag
);

    logic flag_d;
    logic flag_q;

    always_comb begin
        flag_d = flag_q;
        if (hold_zero) begin
            flag_d = 1'b0;
        end else if (set_evt) begin
            flag_d = 1'b1;
        end else if (clr_req) begin
            flag_d = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else begin
            flag_q <= flag_d;
        end
    end

    assign flag = flag_q;

endmodule

// File: rtl/can_errstat_tracker.sv
module can_errstat_tracker
    import can_errstat_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   hold_zero,
    input  logic   clr_req,
    input  errst_e live_rx,
    input  errst_e live_tx,
    output errst_e rstat,
    output errst_e tstat,
    output logic   csc
);

    trk_state_t s_d;
    trk_state_t s_q;
    logic       mismatch;

    always_comb begin
        s_d      = s_q;
        mismatch = (live_rx != s_q.rstat) || (live_tx != s_q.tstat);
        if (s_q.csc) begin
            // Pending change: status frozen, flag only leaves by clear or init
            if (hold_zero || clr_req) begin
                s_d.csc = 1'b0;
            end
        end else if (mismatch) begin
            s_d.rstat = live_rx;
            s_d.tstat = live_tx;
            s_d.csc   = !hold_zero;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{rstat: ST_OK, tstat: ST_OK, csc: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign rstat = s_q.rstat;
    assign tstat = s_q.tstat;
    assign csc   = s_q.csc;

endmodule

// File: rtl/can_errstat_reg.sv
module can_errstat_reg
    import can_errstat_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int REG_OFFSET  = 4,
    parameter int CNT_W       = 9,
    parameter int WARN_LIM    = 96,
    parameter int PASSIVE_LIM = 127,
    parameter int BUSOFF_LIM  = 255
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    input  logic              init_req,
    input  logic              init_ack,
    input  logic              sleep_mode,
    input  logic              bus_activity,
    input  logic              overrun_evt,
    input  logic              rxfull_evt,
    input  logic [CNT_W-1:0]  tx_err_cnt,
    input  logic [CNT_W-1:0]  rx_err_cnt,
    input  logic [3:0]        irq_en,
    output logic [3:0]        irq
);

    localparam logic [ADDR_W-1:0] OFFSET_A   = ADDR_W'(REG_OFFSET);
    localparam logic [CNT_W-1:0]  BUSOFF_CMP = CNT_W'(BUSOFF_LIM);

    logic                     init_active;
    logic                     write_open;
    logic                     reg_sel;
    logic                     wr_hit;
    flagreg_t                 wr_mask;
    logic                     tx_busoff;
    logic [CNT_W-1:0]         cnt_arr [NUM_CNT];
    errst_e                   live_arr [NUM_CNT];
    logic [NUM_EVT_FLAGS-1:0] evt_set;
    logic [NUM_EVT_FLAGS-1:0] evt_clr;
    logic [NUM_EVT_FLAGS-1:0] evt_flag;
    errst_e                   rstat;
    errst_e                   tstat;
    logic                     csc;
    flagreg_t                 reg_view;

    // Mode and access decode
    assign init_active = init_req && init_ack;
    assign write_open  = !init_req && !init_ack;
    assign reg_sel     = (addr == OFFSET_A);
    assign wr_hit      = wr_en && reg_sel && write_open;
    assign wr_mask     = flagreg_t'(wdata);

    // Counter classification, one slice per counter
    assign tx_busoff       = (tx_err_cnt > BUSOFF_CMP);
    assign cnt_arr[CNT_RX] = rx_err_cnt;
    assign cnt_arr[CNT_TX] = tx_err_cnt;

    for (genvar gi = 0; gi < NUM_CNT; gi++) begin : g_level
        can_errstat_level #(
            .CNT_W      (CNT_W),
            .WARN_LIM   (WARN_LIM),
            .PASSIVE_LIM(PASSIVE_LIM)
        ) u_level (
            .cnt      (cnt_arr[gi]),
            .force_off(tx_busoff),
            .level    (live_arr[gi])
        );
    end

    can_errstat_tracker u_tracker (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold_zero(init_active),
        .clr_req  (wr_hit && wr_mask.csc),
        .live_rx  (live_arr[CNT_RX]),
        .live_tx  (live_arr[CNT_TX]),
        .rstat    (rstat),
        .tstat    (tstat),
        .csc      (csc)
    );

    // Strobe-driven sticky flags
    assign evt_set[EVT_RXF]  = rxfull_evt;
    assign evt_set[EVT_OVR]  = overrun_evt;
    assign evt_set[EVT_WAKE] = sleep_mode && bus_activity;
    assign evt_clr[EVT_RXF]  = wr_hit && wr_mask.rxf;
    assign evt_clr[EVT_OVR]  = wr_hit && wr_mask.ovr;
    assign evt_clr[EVT_WAKE] = wr_hit && wr_mask.wake;

    for (genvar gf = 0; gf < NUM_EVT_FLAGS; gf++) begin : g_flag
        can_errstat_flag u_flag (
            .clk      (clk),
            .rst_n    (rst_n),
            .hold_zero(init_active),
            .set_evt  (evt_set[gf]),
            .clr_req  (evt_clr[gf]),
            .flag     (evt_flag[gf])
        );
    end

    always_comb begin
        reg_view       = '0;
        reg_view.wake  = evt_flag[EVT_WAKE];
        reg_view.csc   = csc;
        reg_view.rstat = rstat;
        reg_view.tstat = tstat;
        reg_view.ovr   = evt_flag[EVT_OVR];
        reg_view.rxf   = evt_flag[EVT_RXF];
    end

    assign rdata = reg_sel ? reg_view : 8'h00;
    assign irq   = {reg_view.wake, reg_view.csc, reg_view.ovr, reg_view.rxf} & irq_en;

endmodule

// File: rtl/can_errstat_chk.sv
module can_errstat_chk
    import can_errstat_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int REG_OFFSET  = 4,
    parameter int CNT_W       = 9,
    parameter int WARN_LIM    = 96,
    parameter int PASSIVE_LIM = 127,
    parameter int BUSOFF_LIM  = 255
) (
    input logic              clk,
    input logic              rst_n,
    input logic              init_req,
    input logic              init_ack,
    input logic              sleep_mode,
    input logic              bus_activity,
    input logic              overrun_evt,
    input logic              rxfull_evt,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic              rxf_wbit,
    input logic [CNT_W-1:0]  tx_err_cnt,
    input logic [CNT_W-1:0]  rx_err_cnt,
    input flagreg_t          flags
);

    function automatic logic [1:0] grade(input int unsigned c, input int unsigned t);
        if (t > BUSOFF_LIM)  return 2'b11;
        if (c > PASSIVE_LIM) return 2'b10;
        if (c > WARN_LIM)    return 2'b01;
        return 2'b00;
    endfunction

    logic       in_init;
    logic       can_write;
    logic [3:0] want_status;
    logic [3:0] shown_status;

    assign in_init      = init_req && init_ack;
    assign can_write    = !init_req && !init_ack;
    assign want_status  = {grade(rx_err_cnt, tx_err_cnt), grade(tx_err_cnt, tx_err_cnt)};
    assign shown_status = {flags.rstat, flags.tstat};

    p_init_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        in_init |=> (!flags.wake && !flags.csc && !flags.ovr && !flags.rxf));

    p_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flags.csc |=> ($stable(flags.rstat) && $stable(flags.tstat)));

    p_change_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!flags.csc && !in_init && (want_status != shown_status)) |=> flags.csc);

    p_status_ro_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (want_status == shown_status) |=> $stable(shown_status));

    p_wake_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_mode && bus_activity && !in_init) |=> flags.wake);

    p_set_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun_evt && !in_init) |=> flags.ovr);

    p_clear_rxf_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && can_write && (addr == ADDR_W'(REG_OFFSET)) && rxf_wbit && !rxfull_evt)
        |=> !flags.rxf);

endmodule

bind can_errstat_reg can_errstat_chk #(
    .ADDR_W     (ADDR_W),
    .REG_OFFSET (REG_OFFSET),
    .CNT_W      (CNT_W),
    .WARN_LIM   (WARN_LIM),
    .PASSIVE_LIM(PASSIVE_LIM),
    .BUSOFF_LIM (BUSOFF_LIM)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .init_req    (init_req),
    .init_ack    (init_ack),
    .sleep_mode  (sleep_mode),
    .bus_activity(bus_activity),
    .overrun_evt (overrun_evt),
    .rxfull_evt  (rxfull_evt),
    .wr_en       (wr_en),
    .addr        (addr),
    .rxf_wbit    (wdata[0]),
    .tx_err_cnt  (tx_err_cnt),
    .rx_err_cnt  (rx_err_cnt),
    .flags       (reg_view)
);

// File: tb/can_errstat_reg_tb.sv
module can_errstat_reg_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] addr = 8'h04;
    logic       wr_en = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       init_req = 1'b0;
    logic       init_ack = 1'b0;
    logic       sleep_mode = 1'b0;
    logic       bus_activity = 1'b0;
    logic       overrun_evt = 1'b0;
    logic       rxfull_evt = 1'b0;
    logic [8:0] tec = 9'd0;
    logic [8:0] rec = 9'd0;
    logic [3:0] irq_en = 4'hF;
    logic [3:0] irq;

    int    n_chk = 0;
    int    n_fail = 0;
    string cur_req = "R1";

    // Behavioural reference state
    int m_wake = 0, m_csc = 0, m_rs = 0, m_ts = 0, m_ovr = 0, m_rxf = 0;

    always #5 clk = ~clk;

    can_errstat_reg u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
        .rdata(rdata), .init_req(init_req), .init_ack(init_ack),
        .sleep_mode(sleep_mode), .bus_activity(bus_activity),
        .overrun_evt(overrun_evt), .rxfull_evt(rxfull_evt),
        .tx_err_cnt(tec), .rx_err_cnt(rec), .irq_en(irq_en), .irq(irq)
    );

    function automatic int grade(int c);
        if (c > 127) return 2;
        if (c > 96)  return 1;
        return 0;
    endfunction

    always @(posedge clk) begin : model
        int  lr, lt;
        bit  ini, hit;
        if (!rst_n) begin
            m_wake = 0; m_csc = 0; m_rs = 0; m_ts = 0; m_ovr = 0; m_rxf = 0;
        end else begin
            ini = init_req && init_ack;
            hit = wr_en && (addr == 8'h04) && !init_req && !init_ack;
            lt  = (tec > 255) ? 3 : grade(int'(tec));
            lr  = (tec > 255) ? 3 : grade(int'(rec));
            if (m_csc == 1) begin
                if (ini || (hit && wdata[6])) m_csc = 0;
            end else if (lr != m_rs || lt != m_ts) begin
                m_rs = lr; m_ts = lt;
                m_csc = ini ? 0 : 1;
            end
            if (ini) m_wake = 0;
            else if (sleep_mode && bus_activity) m_wake = 1;
            else if (hit && wdata[7]) m_wake = 0;
            if (ini) m_ovr = 0;
            else if (overrun_evt) m_ovr = 1;
            else if (hit && wdata[1]) m_ovr = 0;
            if (ini) m_rxf = 0;
            else if (rxfull_evt) m_rxf = 1;
            else if (hit && wdata[0]) m_rxf = 0;
        end
    end

    function automatic logic [7:0] exp_rd();
        logic [7:0] v;
        v = {m_wake[0], m_csc[0], m_rs[1:0], m_ts[1:0], m_ovr[0], m_rxf[0]};
        return (addr == 8'h04) ? v : 8'h00;
    endfunction

    function automatic logic [3:0] exp_irq();
        return {m_wake[0], m_csc[0], m_ovr[0], m_rxf[0]} & irq_en;
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // One clock: the edge updates DUT and model, then compare at the falling edge
    task automatic cyc();
        @(negedge clk);
        chk(cur_req, rdata, exp_rd());
        chk("R13 irq", {4'h0, irq}, {4'h0, exp_irq()});
    endtask

    task automatic do_write(input logic [7:0] d);
        wr_en = 1'b1; addr = 8'h04; wdata = d;
        cyc();
        wr_en = 1'b0; wdata = 8'h00;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        // R1: reset state
        cur_req = "R1";
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();
        chk("R1 rdata", rdata, 8'h00);
        chk("R1 irq", {4'h0, irq}, 8'h00);

        // R7 / R5: receiver grading and change flag
        cur_req = "R7";
        rec = 9'd100; cyc();
        chk("R7 set", rdata, 8'h50);
        cur_req = "R3";
        do_write(8'h40);
        chk("R3 clear csc", rdata, 8'h10);
        cur_req = "R5";
        rec = 9'd128; cyc();
        chk("R5 above 127", rdata, 8'h60);

        // R8: frozen while pending
        cur_req = "R8";
        rec = 9'd10; cyc(); cyc();
        chk("R8 freeze", rdata, 8'h60);

        // R9: re-report one edge after clear
        cur_req = "R9";
        do_write(8'h40);
        chk("R9 after clear", rdata, 8'h20);
        cyc();
        chk("R9 re-report", rdata, 8'h40);
        do_write(8'h40);
        chk("R9 quiet", rdata, 8'h00);

        // R5 boundaries
        cur_req = "R5";
        rec = 9'd96; cyc();
        chk("R5 96", rdata, 8'h00);
        rec = 9'd97; cyc();
        chk("R5 97", rdata, 8'h50);
        do_write(8'h40);
        rec = 9'd127; cyc();
        chk("R5 127", rdata, 8'h10);
        rec = 9'd0; cyc();
        do_write(8'h40);

        // R6: transmitter grading and bus-off
        cur_req = "R6";
        tec = 9'd97; cyc();
        chk("R6 97", rdata, 8'h44);
        do_write(8'h40);
        tec = 9'd256; cyc();
        chk("R6 busoff", rdata, 8'h7C);
        do_write(8'h40);
        chk("R6 busoff held", rdata, 8'h3C);
        tec = 9'd255; cyc();
        chk("R6 255", rdata, 8'h48);
        do_write(8'h40);

        // R4: status bits ignore writes
        cur_req = "R4";
        do_write(8'h3C);
        chk("R4 ro", rdata, 8'h08);
        do_write(8'hFF);
        chk("R4 ro all", rdata, 8'h08);
        tec = 9'd0; cyc();
        do_write(8'h40);

        // R11: event flags
        cur_req = "R11";
        overrun_evt = 1'b1; cyc(); overrun_evt = 1'b0;
        chk("R11 ovr", rdata, 8'h02);
        rxfull_evt = 1'b1; cyc(); rxfull_evt = 1'b0;
        chk("R11 rxf", rdata, 8'h03);
        bus_activity = 1'b1; cyc();
        chk("R11 awake activity", rdata, 8'h03);
        sleep_mode = 1'b1; cyc();
        chk("R11 wake", rdata, 8'h83);
        sleep_mode = 1'b0; bus_activity = 1'b0;

        // R3: write semantics
        cur_req = "R3";
        do_write(8'h00);
        chk("R3 zero write", rdata, 8'h83);
        wr_en = 1'b1; addr = 8'h05; wdata = 8'h83; cyc();
        wr_en = 1'b0; wdata = 8'h00; addr = 8'h04; cyc();
        chk("R3 other addr", rdata, 8'h83);
        do_write(8'h81);
        chk("R3 partial", rdata, 8'h02);

        // R12: set beats clear
        cur_req = "R12";
        overrun_evt = 1'b1; do_write(8'h02); overrun_evt = 1'b0;
        chk("R12 set wins", rdata, 8'h02);
        do_write(8'h02);
        chk("R12 cleared", rdata, 8'h00);

        // R13: interrupt gating
        cur_req = "R13";
        irq_en = 4'b1010;
        overrun_evt = 1'b1; rxfull_evt = 1'b1; cyc();
        overrun_evt = 1'b0; rxfull_evt = 1'b0;
        chk("R13 mask a", {4'h0, irq}, 8'h02);
        irq_en = 4'b0101; cyc();
        chk("R13 mask b", {4'h0, irq}, 8'h01);
        do_write(8'h03);
        irq_en = 4'hF;

        // R10: initialization mode
        cur_req = "R10";
        overrun_evt = 1'b1; cyc(); overrun_evt = 1'b0;
        init_req = 1'b1;
        do_write(8'h02);
        chk("R10 write in transition", rdata, 8'h02);
        init_ack = 1'b1; cyc();
        chk("R10 held", rdata, 8'h00);
        overrun_evt = 1'b1; cyc(); overrun_evt = 1'b0;
        chk("R10 evt ignored", rdata, 8'h00);
        tec = 9'd150; cyc();
        chk("R10 status tracks", rdata, 8'h08);
        init_ack = 1'b0; cyc();
        init_req = 1'b0; cyc();
        chk("R10 exit", rdata, 8'h08);
        tec = 9'd0; cyc();
        do_write(8'h40);

        // R2: address decode
        cur_req = "R2";
        rxfull_evt = 1'b1; cyc(); rxfull_evt = 1'b0;
        addr = 8'h00; cyc();
        chk("R2 other addr", rdata, 8'h00);
        addr = 8'h04; cyc();
        chk("R2 offset", rdata, 8'h01);
        do_write(8'h01);

        summary();
        $finish;
    end

endmodule